// File: doc/BRIEF.md
# RGB Channel Multiplexer Sequencer

This block drives the colour select of a converter shared between red, green and blue inputs, and labels every conversion result with the colour it came from. It runs on the converter clock. In rotating mode it steps red, green, blue, red on successive converter clocks, so three clocks make one pixel. In single-colour mode a two-bit pointer holds one colour. A forcing input lets two external pins pick the colour directly. An active-low start-of-line strobe brings the select back to red.

Conversion results leave the converter a fixed number of clocks after the sample. The sequencer delays the select by that latency and presents it as a tag with a valid flag, so the tag matches each result. If a reserved code arrives on the pointer or on the external pins, the current colour is held and an error flag is raised.

Top module: `rgb_chan_seq`

## Requirements
- R1: While `line_start_n` is low at a rising clock edge, `chan_sel` becomes red (00) and `bad_code` clears on that edge.
- R2: With `line_start_n` high, `ext_sel_n` high and `single_ch` low, `chan_sel` advances red(00) to green(01) to blue(10) to red at each rising edge.
- R3: With `line_start_n` high, `ext_sel_n` high and `single_ch` high, `chan_sel` takes `color_ptr` at each edge. The codes are 00 red, 01 green and 10 blue.
- R4: With `line_start_n` high and `ext_sel_n` low, `chan_sel` takes `ext_pick` at each edge, with the same 00/01/10 coding.
- R5: Selection priority, from highest to lowest, is start-of-line, then external forcing, then the single-colour pointer, then rotation.
- R6: If the code in use (`ext_pick` when forced, otherwise `color_ptr` in single-colour mode) is 11, `chan_sel` keeps its value and `bad_code` goes high. Any later edge that applies a valid code or a rotation step clears `bad_code`.
- R7: While `tag_vld` is high, `tag` equals the value `chan_sel` had LAT clock edges earlier.
- R8: `tag_vld` is low after reset and after each start-of-line edge. It rises once LAT more edges have passed with `line_start_n` high, and it then stays high until the next start-of-line.
- R9: Asynchronous active-low `rst_n` sets `chan_sel` and `tag` to red and clears `tag_vld` and `bad_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start_n | input | 1 | Start-of-line strobe, active low |
| single_ch | input | 1 | Selects single-colour mode instead of rotation |
| color_ptr | input | 2 | Colour pointer for single-colour mode |
| ext_sel_n | input | 1 | External forcing enable, active low |
| ext_pick | input | 2 | Externally forced colour code |
| chan_sel | output | 2 | Current colour select |
| tag | output | 2 | Colour of the result leaving the converter |
| tag_vld | output | 1 | Tag is meaningful |
| bad_code | output | 1 | A reserved code was applied on the last edge |

## Verification
The bench builds two copies of the block side by side: one with the default latency of 4, and one with a latency of 1, where a single pipeline stage sits against the start-of-line clearing. Both copies share the same stimulus. The bench runs directed phases for rotation, pointer and forced selection, reserved codes, and overlapping priorities, followed by a long random run that produces short lines and start-of-line pulses in the middle of a pixel. A queue of past selections in the reference gives the expected tag for each latency.

// File: rtl/rgb_chan_seq.sv
module rgb_chan_seq #(
  parameter int LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start_n,
  input  logic       single_ch,
  input  logic [1:0] color_ptr,
  input  logic       ext_sel_n,
  input  logic [1:0] ext_pick,
  output logic [1:0] chan_sel,
  output logic [1:0] tag,
  output logic       tag_vld,
  output logic       bad_code
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] FULL = CW'(LAT);

  logic          use_code;
  logic [1:0]    code;
  logic          reserved;
  logic [1:0]    rot_next;
  logic [CW-1:0] cnt;
  logic [1:0]    pipe [LAT];

  assign use_code = !ext_sel_n || single_ch;
  assign code     = !ext_sel_n ? ext_pick : color_ptr;
  assign reserved = use_code && (code == 2'd3);
  assign rot_next = (chan_sel == 2'd2) ? 2'd0 : chan_sel + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_sel <= 2'd0;
      bad_code <= 1'b0;
    end else if (!line_start_n) begin
      chan_sel <= 2'd0;
      bad_code <= 1'b0;
    end else if (reserved) begin
      bad_code <= 1'b1;
    end else begin
      bad_code <= 1'b0;
      chan_sel <= use_code ? code : rot_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!line_start_n)
      cnt <= '0;
    else if (cnt != FULL)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) pipe[i] <= 2'd0;
    end else begin
      pipe[0] <= chan_sel;
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign tag     = pipe[LAT-1];
  assign tag_vld = (cnt == FULL);

  // R1
  line_start_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start_n |=> (chan_sel == 2'd0) && !bad_code);

  // R2
  rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_n && ext_sel_n && !single_ch) |=>
      (chan_sel != $past(chan_sel)) && (chan_sel != 2'd3) && !bad_code);

  // R4
  ext_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_n && !ext_sel_n && ext_pick != 2'd3) |=> chan_sel == $past(ext_pick));

  // R6
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_n && !ext_sel_n && ext_pick == 2'd3) |=> bad_code && $stable(chan_sel));

  // R8
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start_n |=> !tag_vld);

  // R8
  vld_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_vld && line_start_n) |=> tag_vld);

  // R7
  tag_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_vld |-> tag != 2'd3);
endmodule

// File: tb/tb_rgb_chan_seq.sv
module tb_rgb_chan_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, line_start_n, single_ch, ext_sel_n;
  logic [1:0] color_ptr, ext_pick;
  logic [1:0] chan_a, tag_a, chan_b, tag_b;
  logic       vld_a, bad_a, vld_b, bad_b;

  rgb_chan_seq #(.LAT(4)) dut (
    .clk(clk), .rst_n(rst_n), .line_start_n(line_start_n), .single_ch(single_ch),
    .color_ptr(color_ptr), .ext_sel_n(ext_sel_n), .ext_pick(ext_pick),
    .chan_sel(chan_a), .tag(tag_a), .tag_vld(vld_a), .bad_code(bad_a));

  rgb_chan_seq #(.LAT(1)) dut_l1 (
    .clk(clk), .rst_n(rst_n), .line_start_n(line_start_n), .single_ch(single_ch),
    .color_ptr(color_ptr), .ext_sel_n(ext_sel_n), .ext_pick(ext_pick),
    .chan_sel(chan_b), .tag(tag_b), .tag_vld(vld_b), .bad_code(bad_b));

  int vectors = 0, errs = 0;
  int m_chan = 0, m_bad = 0, m_cnt = 0;
  int hist[$];
  bit done = 0;

  task automatic chk(string r, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step(bit ls, bit en, int ep, bit sc, int cp);
    string lbl;
    int code;
    bit use_code;
    line_start_n = ls; ext_sel_n = en; ext_pick = 2'(ep);
    single_ch = sc; color_ptr = 2'(cp);
    @(posedge clk);
    #1;
    use_code = !en || sc;
    code = !en ? ep : cp;
    if (!ls) lbl = "R1"; else if (!en) lbl = "R4"; else if (sc) lbl = "R3"; else lbl = "R2";
    if ((!ls && (!en || sc)) || (!en && sc)) lbl = "R5";
    if (!ls) begin
      m_chan = 0; m_bad = 0; m_cnt = 0;
    end else begin
      m_cnt++;
      if (use_code && code == 3) begin
        m_bad = 1; lbl = "R6";
      end else begin
        m_bad = 0;
        m_chan = use_code ? code : (m_chan + 1) % 3;
      end
    end
    hist.push_front(m_chan);
    if (hist.size() > 8) void'(hist.pop_back());
    @(negedge clk);
    chk(lbl, chan_a, m_chan);
    chk(lbl, chan_b, m_chan);
    chk("R6", bad_a, m_bad);
    chk("R8", vld_a, m_cnt >= 4);
    chk("R8", vld_b, m_cnt >= 1);
    if (m_cnt >= 4) chk("R7", tag_a, hist[4]);
    if (m_cnt >= 1) chk("R7", tag_b, hist[1]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 0; line_start_n = 1; single_ch = 0; ext_sel_n = 1;
    color_ptr = 0; ext_pick = 0;
    for (int i = 0; i < 8; i++) hist.push_front(0);
    #20;
    // R9 reset state
    chk("R9", chan_a, 0); chk("R9", tag_a, 0); chk("R9", vld_a, 0); chk("R9", bad_a, 0);
    @(negedge clk);
    rst_n = 1;
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < 12; i++) step(1, 1, 0, 0, 0);
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 3; i++) step(1, 1, 0, 1, p);
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0);
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 2; i++) step(1, 0, p, 1, (p + 1) % 3);
    step(1, 0, 3, 0, 0);
    step(1, 0, 3, 0, 0);
    step(1, 1, 0, 1, 3);
    step(1, 1, 0, 0, 0);
    step(0, 0, 2, 1, 1);
    step(0, 0, 3, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 0, 1, 1, 2);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      step(r > 3, $urandom_range(0, 9) != 0, $urandom_range(0, 3),
           $urandom_range(0, 5) == 0, $urandom_range(0, 3));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule